// File: doc/BRIEF.md
# Interrupt Acknowledge Controller

This block decides, for a microcoded 8-bit processor, whether the next instruction starts with an ordinary opcode fetch, an acknowledge fetch or a return to the halt loop. It watches an interrupt request line and records a request only while interrupts are enabled. It keeps the enable bit, which microcode sets and clears with one-cycle strobes. When the sequencer signals the last micro-step of an instruction, the block reports its boundary choice on a two-bit select output. If it accepts an interrupt, it drops the pending request and disables further interrupts.

After an acceptance the acknowledge output stays high for the whole of the vectored instruction, from its fetch to its end strobe. Because of this, an opcode of any length that an external device supplies runs as the vector. The automatic program-counter increment is held off for that whole instruction, while explicit program-counter writes by the microcode still take effect. The block also holds the halt state. Only an accepted interrupt or a reset ends it.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every state bit is cleared: `irq_pending`, `ack_active`, `pc_inc_hold` and `halted` read 0 afterwards, and interrupts are disabled.
- R2: A high `en_set` at a rising edge enables interrupts and a high `en_clr` disables them. When both are high, disable wins.
- R3: A high `irq_req` at a rising edge while interrupts are enabled makes `irq_pending` read 1 after that edge. While interrupts are disabled the request leaves `irq_pending` unchanged.
- R4: `irq_pending` stays set and `ack_active` stays low until an edge at which `instr_end` is high.
- R5: At an edge where `instr_end` and `irq_pending` are both high, the interrupt is accepted. After that edge `irq_pending` is 0, `ack_active` is 1 and interrupts are disabled, even if `en_set` was high at the same edge.
- R6: Once set, `ack_active` stays high until the next edge with `instr_end` high, and after that edge it reads 0 (unless another acceptance takes place at that edge). `pc_inc_hold` always equals `ack_active`.
- R7: When the vectored instruction has finished, interrupts remain disabled: a request is not recorded until `en_set` is pulsed again.
- R8: At an edge with `instr_end` and `halt_req` high and no pending interrupt, `halted` becomes 1. It then stays 1 across further instruction ends, with or without `halt_req`.
- R9: `halted` is cleared only by an acceptance or by reset. If `halt_req`, `instr_end` and `irq_pending` are high together, the interrupt is accepted and `halted` reads 0.
- R10: `bound_sel` is a combinational output. It reads 2'b00 while `instr_end` is low. With `instr_end` high it reads 2'b10 if `irq_pending` is set, otherwise 2'b11 if `halt_req` is high, otherwise 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request level, sampled every edge |
| instr_end | input | 1 | Strobe on the last micro-step of an instruction |
| halt_req | input | 1 | Halt flag of the current micro-step |
| en_set | input | 1 | Enable-interrupts strobe |
| en_clr | input | 1 | Disable-interrupts strobe |
| bound_sel | output | 2 | Boundary choice: 00 none, 01 fetch, 10 acknowledge fetch, 11 halt loop |
| irq_pending | output | 1 | A recorded, not yet accepted request |
| ack_active | output | 1 | Acknowledge, high for the whole vectored instruction |
| pc_inc_hold | output | 1 | Suppresses the automatic program-counter increment |
| halted | output | 1 | Processor is in the halt state |

## Verification
`bound_sel` is combinational, so each test reads it shortly after driving the inputs, in the same cycle as the stimulus. `irq_pending`, `ack_active`, `pc_inc_hold` and `halted` change one rising edge after the stimulus that affects them. The bench drives inputs on falling edges and reads these registered outputs at the next falling edge, before new inputs go out. The enable bit has no output of its own. Each test therefore observes it through whether a later request shows up on `irq_pending` one edge later.

// File: rtl/irq_ack_pkg.sv
// Package: shared types for the interrupt acknowledge controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_ack_pkg;

    // Boundary choice reported to the micro-sequencer at an instruction end.
    typedef enum logic [1:0] {
        BSEL_NONE  = 2'b00,
        BSEL_FETCH = 2'b01,
        BSEL_ACK   = 2'b10,
        BSEL_HALT  = 2'b11
    } bsel_e;

    localparam int BSEL_W = $bits(bsel_e);

endpackage

// File: rtl/irq_capture.sv
// Module: irq_capture
// Holds the interrupt-enable bit and the pending-request flag.
// Assumes: accept is high only at an instruction end while pending is set;
// an acceptance clears both bits and outranks every strobe in that cycle.
module irq_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic en_set,
    input  logic en_clr,
    input  logic accept,
    output logic pending,
    output logic enabled
);

    // Enable bit: disable and acceptance outrank enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enabled <= 1'b0;
        else if (accept || en_clr)
            enabled <= 1'b0;
        else if (en_set)
            enabled <= 1'b1;
    end

    // Pending flag: recorded only while enabled, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (accept)
            pending <= 1'b0;
        else if (irq_req && enabled)
            pending <= 1'b1;
    end

    // R3: a new pending flag needs a request seen while enabled.
    assert_pending_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !$past(pending)) |-> $past(irq_req && enabled));

    // R5: an acceptance leaves interrupts disabled and nothing pending.
    assert_accept_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!enabled && !pending));

endmodule

// File: rtl/ack_sequencer.sv
// Module: ack_sequencer
// Chooses the boundary action at each instruction end and holds the
// acknowledge state for the whole vectored instruction.
// Assumes: instr_end is a single-cycle strobe per instruction.
module ack_sequencer
    import irq_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end,
    input  logic              halt_req,
    input  logic              pending,
    output logic              accept,
    output logic [BSEL_W-1:0] sel,
    output logic              inta
);

    bsel_e sel_q;

    // Boundary choice: pending interrupt, then halt, then plain fetch.
    always_comb begin
        accept = instr_end && pending;
        if (!instr_end)
            sel_q = BSEL_NONE;
        else if (pending)
            sel_q = BSEL_ACK;
        else if (halt_req)
            sel_q = BSEL_HALT;
        else
            sel_q = BSEL_FETCH;
        sel = sel_q;
    end

    // Acknowledge state: raised by acceptance, dropped at the next end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inta <= 1'b0;
        else if (accept)
            inta <= 1'b1;
        else if (instr_end)
            inta <= 1'b0;
    end

    // R6: acknowledge holds for the whole vectored instruction.
    assert_inta_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !instr_end) |=> inta);

    // R6: acknowledge drops after an end that accepts nothing.
    assert_inta_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && !pending) |=> !inta);

    // R5: acknowledge rises only after an acceptance.
    assert_inta_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inta) |-> $past(accept));

endmodule

// File: rtl/halt_tracker.sv
// Module: halt_tracker
// Holds the halt state; entered by halt+end without a pending interrupt,
// left only by acceptance or reset.
// Assumes: accept comes from the same boundary decision as this entry rule.
module halt_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_end,
    input  logic halt_req,
    input  logic pending,
    input  logic accept,
    output logic halted
);

    // Halt state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (accept)
            halted <= 1'b0;
        else if (instr_end && halt_req && !pending)
            halted <= 1'b1;
    end

    // R9: the halt state persists unless an interrupt is accepted.
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !accept) |=> halted);

    // R9: acceptance always leaves the halt state.
    assert_halt_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !halted);

endmodule

// File: rtl/irq_ack_ctrl.sv
// Module: irq_ack_ctrl (top)
// Interrupt acceptance for a microcoded CPU: records requests while
// enabled, picks the boundary action, drives acknowledge and the
// program-counter increment hold, and keeps the halt state.
// Assumes: all strobes are synchronous to clk; reset is synchronous, active low.
module irq_ack_ctrl
    import irq_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              instr_end,
    input  logic              halt_req,
    input  logic              en_set,
    input  logic              en_clr,
    output logic [BSEL_W-1:0] bound_sel,
    output logic              irq_pending,
    output logic              ack_active,
    output logic              pc_inc_hold,
    output logic              halted
);

    logic accept;
    logic enabled;

    irq_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .accept  (accept),
        .pending (irq_pending),
        .enabled (enabled)
    );

    ack_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_end (instr_end),
        .halt_req  (halt_req),
        .pending   (irq_pending),
        .accept    (accept),
        .sel       (bound_sel),
        .inta      (ack_active)
    );

    halt_tracker u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_end (instr_end),
        .halt_req  (halt_req),
        .pending   (irq_pending),
        .accept    (accept),
        .halted    (halted)
    );

    // Increment hold follows the acknowledge state.
    always_comb pc_inc_hold = ack_active;

    // R7: while acknowledge is high, no new request can be pending unless re-enabled.
    assert_no_pending_without_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_active && !enabled) |=> (irq_pending == $past(irq_pending)) || !irq_pending);

endmodule

// File: tb/irq_ack_ctrl_test.sv
`timescale 1ns/1ps
module irq_ack_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       irq_req, instr_end, halt_req, en_set, en_clr;
    logic [1:0] bound_sel;
    logic       irq_pending, ack_active, pc_inc_hold, halted;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    irq_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_end(instr_end),
        .halt_req(halt_req), .en_set(en_set), .en_clr(en_clr),
        .bound_sel(bound_sel), .irq_pending(irq_pending),
        .ack_active(ack_active), .pc_inc_hold(pc_inc_hold), .halted(halted)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at a falling edge.
    task automatic drive(input logic ir, input logic en, input logic hl,
                         input logic es, input logic ec);
        @(negedge clk);
        irq_req = ir; instr_end = en; halt_req = hl; en_set = es; en_clr = ec;
        #0.5;
    endtask

    task automatic idle(); drive(0, 0, 0, 0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        irq_req = 0; instr_end = 0; halt_req = 0; en_set = 0; en_clr = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pending", {1'b0, irq_pending}, 2'd0);
        chk("R1 inta", {1'b0, ack_active}, 2'd0);
        chk("R1 hold", {1'b0, pc_inc_hold}, 2'd0);
        chk("R1 halted", {1'b0, halted}, 2'd0);
        chk("R10 sel none", bound_sel, 2'b00);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R1 disabled after reset", {1'b0, irq_pending}, 2'd0);
    endtask

    task automatic t_masked_and_pending();
        drive(1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R3 masked request", {1'b0, irq_pending}, 2'd0);
        drive(0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R3 recorded request", {1'b0, irq_pending}, 2'd1);
        idle(); idle();
        chk("R4 pending held", {1'b0, irq_pending}, 2'd1);
        chk("R4 no early inta", {1'b0, ack_active}, 2'd0);
        chk("R10 sel none mid", bound_sel, 2'b00);
    endtask

    task automatic t_accept_and_vector();
        drive(0, 1, 0, 0, 0);
        chk("R10 sel ack", bound_sel, 2'b10);
        drive(1, 0, 0, 0, 0);
        chk("R5 pending cleared", {1'b0, irq_pending}, 2'd0);
        chk("R5 inta set", {1'b0, ack_active}, 2'd1);
        chk("R6 hold set", {1'b0, pc_inc_hold}, 2'd1);
        idle();
        chk("R5 disabled by accept", {1'b0, irq_pending}, 2'd0);
        idle(); idle();
        chk("R6 inta held", {1'b0, ack_active}, 2'd1);
        drive(0, 1, 0, 0, 0);
        chk("R10 sel fetch", bound_sel, 2'b01);
        idle();
        chk("R6 inta dropped", {1'b0, ack_active}, 2'd0);
        chk("R6 hold dropped", {1'b0, pc_inc_hold}, 2'd0);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R7 still disabled", {1'b0, irq_pending}, 2'd0);
    endtask

    task automatic t_enable_strobes();
        drive(0, 0, 0, 1, 1);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R2 disable wins", {1'b0, irq_pending}, 2'd0);
        drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 1);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R2 disable strobe", {1'b0, irq_pending}, 2'd0);
    endtask

    task automatic t_halt();
        drive(0, 1, 1, 0, 0);
        chk("R10 sel halt", bound_sel, 2'b11);
        idle();
        chk("R8 halted set", {1'b0, halted}, 2'd1);
        drive(0, 1, 1, 0, 0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R8 halted sticky", {1'b0, halted}, 2'd1);
        drive(0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0);
        idle();
        drive(0, 1, 1, 0, 0);
        chk("R9 sel ack over halt", bound_sel, 2'b10);
        idle();
        chk("R9 halt left by accept", {1'b0, halted}, 2'd0);
        chk("R9 inta on exit", {1'b0, ack_active}, 2'd1);
        drive(0, 1, 0, 0, 0);
        idle();
    endtask

    task automatic t_halt_reset();
        drive(0, 1, 1, 0, 0);
        idle();
        chk("R8 halted again", {1'b0, halted}, 2'd1);
        do_reset();
        chk("R1 halt cleared by reset", {1'b0, halted}, 2'd0);
    endtask

    task automatic t_accept_vs_enable();
        drive(0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0);
        idle();
        drive(0, 1, 0, 1, 0);
        drive(1, 0, 0, 0, 0);
        idle();
        chk("R5 accept outranks enable", {1'b0, irq_pending}, 2'd0);
        drive(0, 1, 0, 0, 0);
        idle();
    endtask

    initial begin
        #40000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        irq_req = 0; instr_end = 0; halt_req = 0; en_set = 0; en_clr = 0;
        t_reset();
        t_masked_and_pending();
        t_accept_and_vector();
        t_enable_strobes();
        t_halt();
        t_halt_reset();
        t_accept_vs_enable();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule